// File: doc/BRIEF.md
# Conversion Sequencer for a Sampling Converter

This block steps an external analog converter through each conversion in three phases. First the input settles in an acquisition phase whose length is programmable. Then the converter is started and the block waits for its done handshake. A fixed recovery hold follows before sampling resumes. Time in the acquisition and recovery phases is counted in ticks of a conversion clock, supplied as a one-cycle enable pulse on the system clock.

A sequence starts in one of two ways. Software can pulse a start request, or a pulse can arrive on one of four hardware trigger lines, chosen by a 2-bit select. Both need the module enable, and a software start in the same cycle that the enable is switched on is ignored. Software can abort a sequence by clearing the busy flag. After an abort the result register keeps its old contents. A start that arrives while a sequence or its recovery hold is running is held and taken up when the hold ends.

On a normal finish the converter's data word goes into the result register, the busy flag drops and a one-cycle completion interrupt fires. Software may also load the result register directly.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, busy, convStart and doneIrq are 0, sampleHold is 1 and result is 0.
- R2: A swStartSet pulse sets busy on the next clock edge, but only when regEnable is 1 in that cycle and was also 1 in the cycle before. A swStartSet while regEnable is 0, or in the first cycle regEnable is 1, has no effect and leaves no pending start.
- R3: At the start edge, acqSel is captured and gives the acquisition length in convTick pulses: 0→0, 1→2, 2→4, 3→6, 4→8, 5→12, 6→16, 7→20. Once that many ticks have passed, convStart pulses on the next cycle. With code 0, convStart is high in the cycle right after the first cycle in which busy is 1.
- R4: sampleHold is 1 while idle or acquiring and 0 during conversion and recovery.
- R5: adcDone during conversion writes adcData into result, clears busy and raises doneIrq on the next edge.
- R6: swStartClr while busy aborts the sequence. Busy clears on the next edge, doneIrq stays 0, result is unchanged, and a later adcDone for that conversion is ignored.
- R7: After a completion or an abort, sampleHold returns to 1 three cycles after busy falls when convTick is high every cycle. This is a recovery hold of 2 ticks.
- R8: Only trigIn[trigSel] can start a sequence. Code 3 selects the alarm line, 2 the timer-overflow line, 1 the charge-measurement line and 0 the capture/compare line. The other lines have no effect.
- R9: While regEnable is 0, trigger pulses are ignored and busy stays 0.
- R10: A start (software or trigger) that arrives while busy or during recovery is held. When the recovery hold ends, busy rises in the same cycle that sampleHold returns to 1. An abort or a 0 on regEnable drops the held start.
- R11: resWrEn loads resWrData into result. If adcDone completes a conversion in the same cycle, the converter data wins.
- R12: convStart and doneIrq are each high for exactly one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regEnable | input | 1 | Module enable bit |
| swStartSet | input | 1 | Software start request pulse |
| swStartClr | input | 1 | Software clear of busy (abort) pulse |
| acqSel | input | 3 | Acquisition time code |
| trigSel | input | 2 | Hardware trigger select |
| trigIn | input | 4 | Hardware trigger pulses, indexed by trigSel code |
| convTick | input | 1 | Conversion-clock tick enable |
| adcDone | input | 1 | Converter finished pulse |
| adcData | input | DATA_W | Converter data word |
| resWrEn | input | 1 | Software write strobe for the result register |
| resWrData | input | DATA_W | Software write data |
| sampleHold | output | 1 | 1 = sample, 0 = hold |
| convStart | output | 1 | Converter start strobe |
| busy | output | 1 | Start/busy flag |
| doneIrq | output | 1 | Completion interrupt pulse |
| result | output | DATA_W | Result register |

## Verification
A wrong phase counter shows up first at convStart: the strobe comes early or late by a whole number of ticks within 21 ticks of the start. A wrong recovery count shows as sampleHold or a held start coming back on the wrong cycle. A state machine stuck in the wrong phase shows at once as sampleHold and busy disagreeing with the phase the bench expects. A result update on a bad path, such as an abort, a collision or a stray adcDone, stays visible on result until the next completion, so the bench checks it right after the event that could have disturbed it.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACQ   = 2'd1,
    ST_CONV  = 2'd2,
    ST_RECOV = 2'd3
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchResult;
    logic takeStart;
    logic dropPending;
  } ctrlStrobes_t;

  localparam int ACQ_CODE_W = 3;
  localparam int CNT_W      = 5;

  // Acquisition length in conversion-clock ticks per code
  function automatic logic [CNT_W-1:0] acqTicks(input logic [ACQ_CODE_W-1:0] code);
    logic [CNT_W-1:0] t;
    if (code < 3'd5) t = CNT_W'({code, 1'b0});
    else             t = CNT_W'((code - 3'd2) << 2);
    return t;
  endfunction

endpackage

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int NUM_TRIG = 4,
  localparam int SEL_W   = $clog2(NUM_TRIG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regEnable,
  input  logic              swStartSet,
  input  logic [SEL_W-1:0]  trigSel,
  input  logic [NUM_TRIG-1:0] trigIn,
  input  logic [DATA_W-1:0] adcData,
  input  logic              resWrEn,
  input  logic [DATA_W-1:0] resWrData,
  input  ctrlStrobes_t      strobes,
  output logic              newStart,
  output logic              pendingQ,
  output logic [DATA_W-1:0] result
);

  logic enPrev;
  logic trigHit;
  logic swOk;
  logic [NUM_TRIG-1:0] trigMask;

  // Select one trigger line through a decoded mask
  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_trig
    assign trigMask[g] = (trigSel == SEL_W'(g)) & trigIn[g];
  end

  assign trigHit  = |trigMask;
  assign swOk     = swStartSet & enPrev;
  assign newStart = regEnable & (swOk | trigHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enPrev <= 1'b0;
    else       enPrev <= regEnable;
  end

  // Held start request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                      pendingQ <= 1'b0;
    else if (!regEnable || strobes.dropPending)     pendingQ <= 1'b0;
    else if (strobes.takeStart)                     pendingQ <= 1'b0;
    else if (newStart)                              pendingQ <= 1'b1;
  end

  // Result register: converter data wins over a software write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    result <= '0;
    else if (strobes.latchResult) result <= adcData;
    else if (resWrEn)             result <= resWrData;
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RECOV_TICKS = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regEnable,
  input  logic                  swStartClr,
  input  logic [ACQ_CODE_W-1:0] acqSel,
  input  logic                  convTick,
  input  logic                  adcDone,
  input  logic                  newStart,
  input  logic                  pendingQ,
  output ctrlStrobes_t          strobes,
  output logic                  sampleHold,
  output logic                  convStart,
  output logic                  busy,
  output logic                  doneIrq
);

  localparam logic [CNT_W-1:0] RECOV_LOAD = CNT_W'(RECOV_TICKS);

  seqState_t        state;
  logic [CNT_W-1:0] tickCnt;
  logic             cntZero;
  logic             inRun;
  logic             abortNow;
  logic             recovExit;
  logic             restart;

  assign cntZero   = (tickCnt == '0);
  assign inRun     = (state == ST_ACQ) || (state == ST_CONV);
  assign abortNow  = inRun && swStartClr;
  assign recovExit = (state == ST_RECOV) && cntZero;
  assign restart   = recovExit && (newStart || (pendingQ && regEnable));

  always_comb begin
    strobes.latchResult = (state == ST_CONV) && adcDone && !swStartClr;
    strobes.takeStart   = ((state == ST_IDLE) && newStart) || restart;
    strobes.dropPending = abortNow;
  end

  assign sampleHold = (state == ST_IDLE) || (state == ST_ACQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      tickCnt   <= '0;
      busy      <= 1'b0;
      convStart <= 1'b0;
      doneIrq   <= 1'b0;
    end else begin
      convStart <= 1'b0;
      doneIrq   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (newStart) begin
            state   <= ST_ACQ;
            tickCnt <= acqTicks(acqSel);
            busy    <= 1'b1;
          end
        end
        ST_ACQ: begin
          if (swStartClr) begin
            state   <= ST_RECOV;
            tickCnt <= RECOV_LOAD;
            busy    <= 1'b0;
          end else if (cntZero) begin
            state     <= ST_CONV;
            convStart <= 1'b1;
          end else if (convTick) begin
            tickCnt <= tickCnt - 1'b1;
          end
        end
        ST_CONV: begin
          if (swStartClr) begin
            state   <= ST_RECOV;
            tickCnt <= RECOV_LOAD;
            busy    <= 1'b0;
          end else if (adcDone) begin
            state   <= ST_RECOV;
            tickCnt <= RECOV_LOAD;
            busy    <= 1'b0;
            doneIrq <= 1'b1;
          end
        end
        ST_RECOV: begin
          if (cntZero) begin
            if (restart) begin
              state   <= ST_ACQ;
              tickCnt <= acqTicks(acqSel);
              busy    <= 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end else if (convTick) begin
            tickCnt <= tickCnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int NUM_TRIG    = 4,
  parameter int RECOV_TICKS = 2,
  localparam int SEL_W      = $clog2(NUM_TRIG)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regEnable,
  input  logic                  swStartSet,
  input  logic                  swStartClr,
  input  logic [ACQ_CODE_W-1:0] acqSel,
  input  logic [SEL_W-1:0]      trigSel,
  input  logic [NUM_TRIG-1:0]   trigIn,
  input  logic                  convTick,
  input  logic                  adcDone,
  input  logic [DATA_W-1:0]     adcData,
  input  logic                  resWrEn,
  input  logic [DATA_W-1:0]     resWrData,
  output logic                  sampleHold,
  output logic                  convStart,
  output logic                  busy,
  output logic                  doneIrq,
  output logic [DATA_W-1:0]     result
);

  ctrlStrobes_t strobes;
  logic         newStart;
  logic         pendingQ;

  adc_seq_ctrl #(.RECOV_TICKS(RECOV_TICKS)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regEnable  (regEnable),
    .swStartClr (swStartClr),
    .acqSel     (acqSel),
    .convTick   (convTick),
    .adcDone    (adcDone),
    .newStart   (newStart),
    .pendingQ   (pendingQ),
    .strobes    (strobes),
    .sampleHold (sampleHold),
    .convStart  (convStart),
    .busy       (busy),
    .doneIrq    (doneIrq)
  );

  adc_seq_dp #(.DATA_W(DATA_W), .NUM_TRIG(NUM_TRIG)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regEnable  (regEnable),
    .swStartSet (swStartSet),
    .trigSel    (trigSel),
    .trigIn     (trigIn),
    .adcData    (adcData),
    .resWrEn    (resWrEn),
    .resWrData  (resWrData),
    .strobes    (strobes),
    .newStart   (newStart),
    .pendingQ   (pendingQ),
    .result     (result)
  );

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              regEnable,
  input logic              swStartClr,
  input logic              resWrEn,
  input logic              sampleHold,
  input logic              convStart,
  input logic              busy,
  input logic              doneIrq,
  input logic [DATA_W-1:0] result
);

  AST_CONV_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);                                             // R12
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq);                                                 // R12
  AST_HOLD_IN_CONV: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> !sampleHold);                                            // R4
  AST_IRQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> !busy);                                                    // R5
  AST_ABORT_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && swStartClr && !resWrEn) |=> ($stable(result) && !doneIrq));   // R6
  AST_BUSY_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (doneIrq || $past(swStartClr)));                       // R6
  AST_OFF_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (!regEnable && !busy) |=> !busy);                                      // R9

endmodule

bind adc_seq_top adc_seq_checker #(.DATA_W(DATA_W)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regEnable  (regEnable),
  .swStartClr (swStartClr),
  .resWrEn    (resWrEn),
  .sampleHold (sampleHold),
  .convStart  (convStart),
  .busy       (busy),
  .doneIrq    (doneIrq),
  .result     (result)
);

// File: tb/test_adc_seq_top.sv
`timescale 1ns/1ps
module test_adc_seq_top;

  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rstN;
  logic          regEnable, swStartSet, swStartClr;
  logic [2:0]    acqSel;
  logic [1:0]    trigSel;
  logic [3:0]    trigIn;
  logic          convTick, adcDone, resWrEn;
  logic [DW-1:0] adcData, resWrData;
  logic          sampleHold, convStart, busy, doneIrq;
  logic [DW-1:0] result;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit slowTick = 0;

  always #4 clk = ~clk;

  adc_seq_top #(.DATA_W(DW)) i_adc_seq_top (
    .clk(clk), .rstN(rstN), .regEnable(regEnable), .swStartSet(swStartSet),
    .swStartClr(swStartClr), .acqSel(acqSel), .trigSel(trigSel), .trigIn(trigIn),
    .convTick(convTick), .adcDone(adcDone), .adcData(adcData), .resWrEn(resWrEn),
    .resWrData(resWrData), .sampleHold(sampleHold), .convStart(convStart),
    .busy(busy), .doneIrq(doneIrq), .result(result)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    cyc++;
    convTick = slowTick ? ((cyc % 3) == 0) : 1'b1;
  endtask

  function automatic int ticksFor(input int code);
    int t [8] = '{0, 2, 4, 6, 8, 12, 16, 20};
    return t[code];
  endfunction

  task automatic swStart();
    swStartSet = 1'b1; step(); swStartSet = 1'b0;
  endtask

  task automatic abortSeq();
    swStartClr = 1'b1; step(); swStartClr = 1'b0;
  endtask

  // Steps until convStart, predicting the cycle from the tick model of R3
  task automatic waitConv(input int n, output int k, output int pk);
    int mc = n;
    bit found = 0;
    k = 0; pk = -1;
    while (!convStart && k < 200) begin
      if (!found) begin
        if (mc == 0) begin found = 1; pk = k + 1; end
        else if (convTick) mc--;
      end
      step();
      k++;
    end
  endtask

  task automatic waitSample(output int k);
    k = 0;
    while (!sampleHold && k < 50) begin step(); k++; end
  endtask

  task automatic finishConv(input logic [DW-1:0] d);
    adcData = d; adcDone = 1'b1; step(); adcDone = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int k, pk;
    logic [DW-1:0] keep;
    rstN = 1'b0; regEnable = 0; swStartSet = 0; swStartClr = 0; acqSel = 0;
    trigSel = 0; trigIn = 0; convTick = 1; adcDone = 0; adcData = 0;
    resWrEn = 0; resWrData = 0;
    repeat (3) step();
    rstN = 1'b1;
    step();
    // R1 reset state
    chk(!busy && !convStart && !doneIrq, "R1 flags", {busy, convStart, doneIrq}, 0);
    chk(sampleHold, "R1 sampleHold", sampleHold, 1);
    chk(result == 0, "R1 result", result, 0);

    // R2 disabled start ignored
    swStart();
    chk(!busy, "R2 start while disabled", busy, 0);
    // R2 start in the cycle enable rises is ignored
    regEnable = 1'b1; swStartSet = 1'b1; step(); swStartSet = 1'b0;
    chk(!busy, "R2 start on enable rise", busy, 0);
    step();
    chk(!busy, "R2 no held start after enable rise", busy, 0);

    // R3/R4/R5/R7/R12 sweep over all acquisition codes, alternating tick rates
    for (int code = 0; code < 8; code++) begin
      logic [DW-1:0] d;
      d = DW'(code * 301 + 7);
      acqSel = 3'(code);
      slowTick = code[0];
      swStart();
      chk(busy, "R2 start accepted", busy, 1);
      chk(sampleHold, "R4 sampling during acquisition", sampleHold, 1);
      waitConv(ticksFor(code), k, pk);
      chk(k == pk, "R3 acquisition length", k, pk);
      if (code == 0) chk(k == 1, "R3 zero code one cycle", k, 1);
      chk(!sampleHold, "R4 hold at conversion", sampleHold, 0);
      slowTick = 0;
      step();
      chk(!convStart, "R12 convStart single cycle", convStart, 0);
      finishConv(d);
      chk(result == d, "R5 result latched", result, d);
      chk(!busy && doneIrq, "R5 busy clear irq set", {busy, doneIrq}, 1);
      step();
      chk(!doneIrq, "R12 doneIrq single cycle", doneIrq, 0);
      chk(!sampleHold, "R4 hold during recovery", sampleHold, 0);
      k = 1;
      while (!sampleHold && k < 50) begin step(); k++; end
      chk(k == 3, "R7 recovery after completion", k, 3);
    end

    // R11 software write, then abort in acquisition keeps it (R6)
    resWrData = 12'hABC; resWrEn = 1'b1; step(); resWrEn = 1'b0;
    chk(result == 12'hABC, "R11 software write", result, 12'hABC);
    acqSel = 3'd3;
    swStart(); step(); step();
    abortSeq();
    chk(!busy && !doneIrq, "R6 abort in acquisition", {busy, doneIrq}, 0);
    chk(result == 12'hABC, "R6 result kept after abort", result, 12'hABC);
    waitSample(k);
    chk(k == 3, "R7 recovery after abort", k, 3);

    // R6 abort during conversion, late adcDone ignored
    acqSel = 3'd0;
    swStart();
    waitConv(0, k, pk);
    abortSeq();
    chk(!busy, "R6 abort in conversion", busy, 0);
    finishConv(12'h123);
    chk(!doneIrq && result == 12'hABC, "R6 late done ignored", result, 12'hABC);
    waitSample(k); step(); step();

    // R11 collision: converter data wins
    swStart();
    waitConv(0, k, pk);
    resWrEn = 1'b1; resWrData = 12'h555; adcData = 12'h0F0; adcDone = 1'b1;
    step();
    resWrEn = 1'b0; adcDone = 1'b0;
    chk(result == 12'h0F0, "R11 done wins collision", result, 12'h0F0);
    waitSample(k); step();

    // R10 held start serviced after recovery
    swStart();
    waitConv(0, k, pk);
    swStart();
    finishConv(12'h321);
    chk(!busy && doneIrq, "R10 completion before held start", busy, 0);
    k = 0;
    while (!busy && k < 50) begin step(); k++; end
    chk(k == 3, "R10 held start cycle", k, 3);
    chk(sampleHold, "R10 sampling resumes with held start", sampleHold, 1);
    waitConv(0, k, pk);
    finishConv(12'h322);
    waitSample(k); step();

    // R10 abort drops held start
    acqSel = 3'd7;
    swStart(); swStart();
    abortSeq();
    repeat (6) step();
    chk(!busy, "R10 abort drops held start", busy, 0);

    // R8 trigger select sweep
    for (int s = 0; s < 4; s++) begin
      for (int j = 0; j < 4; j++) begin
        trigSel = 2'(s); trigIn = 4'(1 << j); step(); trigIn = 0;
        chk(busy == (s == j), $sformatf("R8 sel%0d line%0d", s, j), busy, (s == j));
        if (busy) begin abortSeq(); repeat (4) step(); end
      end
    end

    // R9 triggers ignored while disabled
    regEnable = 1'b0; step();
    for (int s = 0; s < 4; s++) begin
      trigSel = 2'(s); trigIn = 4'hF; step(); trigIn = 0;
      chk(!busy, "R9 trigger while disabled", busy, 0);
    end
    step();
    keep = result;
    chk(!busy && result == keep, "R9 idle after disabled triggers", busy, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule